// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when a DRAM needs refreshing and drives the row strobe, column strobe and write enable while a refresh runs. After reset it waits out a power-up pause. It then runs a burst of warm-up refresh cycles and raises `ready`. From then on a distributed interval timer adds one owed refresh at each expiry. The owed count saturates at a ceiling.

The block shares the DRAM bus with an access sequencer through a level request/grant pair. Owed refreshes are issued back to back once `ref_grant` is seen. At the ceiling the `urgent` flag tells the sequencer to release the bus after its current access.

`row_mode` picks the refresh style. Low selects column-before-row cycles, which use the DRAM's internal counter. High selects row-only cycles, where the block presents a row from its own wrapping counter. `row_mode` must be held steady while out of reset.

Self-refresh is requested with the level input `sr_req`. The block holds both strobes low for at least a minimum time. On exit it keeps the row strobe high for a recovery time and then issues a catch-up. In column-before-row style the catch-up is a single cycle. In row-only style the catch-up is a full sweep of all rows, and a full sweep is also issued just before entry. All times are parameters counted in clock cycles.

Top module: `refresh_scheduler`

## Requirements
- R1: During reset and until initialization completes, `ready`, `ref_req` and `urgent` are low and `ras_n`/`cas_n` are high. No RAS fall occurs in the first PAUSE_CYC cycles after reset is released.
- R2: After the pause, exactly INIT_CNT refresh cycles are issued without a grant, and then `ready` rises and stays high. The cycles are column-before-row when `row_mode`=0 and row-only when `row_mode`=1.
- R3: In a column-before-row cycle, `cas_n` is low in the cycle before `ras_n` falls and is still low at the fall. `we_n` is 1 whenever `ras_n` is low.
- R4: A normal refresh holds `ras_n` low for exactly RAS_LOW_CYC cycles. Successive RAS falls are separated by at least RP_CYC cycles of `ras_n` high.
- R5: In a row-only cycle, `cas_n` stays high and `addr_oe` is 1 at the RAS fall. `row_addr` follows 0, 1, 2, … across successive row-only cycles, and wraps from ROWS-1 to 0.
- R6: `ref_req` rises REF_INTERVAL cycles (±3) after `ready` rises, with no grant involved.
- R7: After `ready`, no refresh starts while `ref_grant` is low. When the grant arrives, the owed refreshes are issued back to back. Their number is min(expiries, DEBT_MAX). `ref_req` then falls.
- R8: `urgent` is high exactly while the owed count equals DEBT_MAX, and it clears once the owed refreshes are served.
- R9: With `sr_req` high and a grant, self-refresh holds `ras_n` and `cas_n` low, with `sr_active`=1, for as long as `sr_req` stays high. The low time is never shorter than SR_MIN_CYC cycles, even if `sr_req` drops earlier.
- R10: After self-refresh in column-before-row style, `ras_n` stays high at least SR_EXIT_CYC cycles. Exactly one catch-up column-before-row cycle follows, and then `ref_req` falls.
- R11: In row-only style, self-refresh is preceded and followed by a full sweep of ROWS row-only cycles. A session therefore gives 2·ROWS+1 RAS falls, of which only the self-refresh one has CAS low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_mode | input | 1 | 0: column-before-row refresh, 1: row-only refresh with internal row counter |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_grant | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Bus request for refresh work |
| urgent | output | 1 | Owed refresh count at its ceiling |
| ready | output | 1 | Initialization finished |
| sr_active | output | 1 | Self-refresh strobe phase in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive high |
| addr_oe | output | 1 | Block drives `row_addr` onto the address bus |
| row_addr | output | ROW_W | Row for row-only refresh |

## Verification
The scheduler is driven with a table of grant delays that let one to five timer expiries pile up before the grant is given. The resulting burst lengths and `urgent` levels show whether the owed count stops at its ceiling or overflows, and whether it is lost or served completely. Self-refresh is tried twice: once with a request shorter than the minimum, which separates the minimum-time floor from following `sr_req`, and once with a long request. It is run in both refresh styles, where the count of CAS-low falls versus row-only falls tells the single catch-up from the full sweeps. A row count that is not a power of two makes the row counter wrap inside the warm-up burst, so wrap errors are visible.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        PH_PAUSE,
        PH_WARM,
        PH_RUN,
        PH_SWEEP,
        PH_SELF,
        PH_CATCH
    } phase_t;

    typedef enum logic [1:0] {
        CY_CBR,
        CY_ROR,
        CY_SELF
    } cyc_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_SETUP,
        EN_LOW,
        EN_PRE
    } eng_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic addr_oe;
    } strobe_t;

    function automatic int width_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int row_bits(input int n);
        return (n < 3) ? 1 : $clog2(n);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refsched_strobe.sv
module refsched_strobe
    import refsched_pkg::*;
#(
    parameter int RAS_LOW_CYC = 3,
    parameter int RP_CYC      = 2,
    parameter int SR_MIN_CYC  = 5000,
    parameter int SR_EXIT_CYC = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  cyc_t    kind,
    input  logic    hold,
    output strobe_t strb,
    output logic    busy,
    output logic    self_low
);
    localparam int LONGEST = max2(max2(RAS_LOW_CYC, RP_CYC), max2(SR_MIN_CYC, SR_EXIT_CYC));
    localparam int CW = width_for(LONGEST);
    localparam logic [CW-1:0] LOW_LAST  = CW'(RAS_LOW_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] SR_LAST   = CW'(SR_MIN_CYC - 1);
    localparam logic [CW-1:0] EXIT_LAST = CW'(SR_EXIT_CYC - 1);

    eng_t          st;
    cyc_t          kind_q;
    logic [CW-1:0] cnt;
    logic          low_end;
    logic          pre_end;

    always_comb begin
        if (kind_q == CY_SELF) begin
            low_end = (cnt >= SR_LAST) && !hold;
            pre_end = (cnt == EXIT_LAST);
        end else begin
            low_end = (cnt == LOW_LAST);
            pre_end = (cnt == PRE_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EN_IDLE;
            kind_q <= CY_CBR;
            cnt    <= '0;
        end else begin
            case (st)
                EN_IDLE: begin
                    if (start) begin
                        st     <= EN_SETUP;
                        kind_q <= kind;
                    end
                end
                EN_SETUP: begin
                    st  <= EN_LOW;
                    cnt <= '0;
                end
                EN_LOW: begin
                    if (low_end) begin
                        st  <= EN_PRE;
                        cnt <= '0;
                    end else if (cnt != '1) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                EN_PRE: begin
                    if (pre_end) st <= EN_IDLE;
                    else         cnt <= cnt + 1'b1;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // Column strobe leads the row strobe by the setup cycle for internal-counter
    // cycles; row-only cycles keep it high and present the address instead.
    always_comb begin
        strb.ras_n   = (st != EN_LOW);
        strb.cas_n   = !((kind_q != CY_ROR) &&
                         ((st == EN_SETUP) ||
                          ((st == EN_LOW) && ((kind_q == CY_SELF) || (cnt == '0)))));
        strb.addr_oe = (kind_q == CY_ROR) && ((st == EN_SETUP) || (st == EN_LOW));
        busy         = (st != EN_IDLE);
        self_low     = (st == EN_LOW) && (kind_q == CY_SELF);
    end

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt
    import refsched_pkg::*;
#(
    parameter int INTERVAL = 780,
    parameter int DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic take,
    output logic owed,
    output logic urgent
);
    localparam int TW = width_for(INTERVAL);
    localparam int DW = width_for(DEBT_MAX);
    localparam logic [TW-1:0] T_LAST = TW'(INTERVAL - 1);
    localparam logic [DW-1:0] D_TOP  = DW'(DEBT_MAX);

    logic [TW-1:0] tcnt;
    logic [DW-1:0] debt;
    logic          tick;
    logic          pay;

    always_comb begin
        tick   = run && (tcnt == T_LAST);
        owed   = (debt != '0);
        urgent = (debt == D_TOP);
        pay    = take && owed;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt <= '0;
            debt <= '0;
        end else begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
            case ({tick, pay})
                2'b10:   if (debt != D_TOP) debt <= debt + 1'b1;
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

endmodule

// File: rtl/refsched_rowctr.sv
module refsched_rowctr
    import refsched_pkg::*;
#(
    parameter int ROWS = 8192,
    localparam int RW = row_bits(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [RW-1:0] row
);
    generate
        if ((ROWS & (ROWS - 1)) == 0) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst)       row <= '0;
                else if (step) row <= row + 1'b1;
            end
        end else begin : g_mod
            localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
            always_ff @(posedge clk) begin
                if (rst)       row <= '0;
                else if (step) row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int PAUSE_CYC    = 5000,
    parameter int INIT_CNT     = 8,
    parameter int REF_INTERVAL = 780,
    parameter int DEBT_MAX     = 8,
    parameter int RAS_LOW_CYC  = 3,
    parameter int RP_CYC       = 2,
    parameter int SR_MIN_CYC   = 5000,
    parameter int SR_EXIT_CYC  = 5,
    parameter int ROWS         = 8192,
    localparam int ROW_W = row_bits(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_mode,
    input  logic             sr_req,
    input  logic             ref_grant,
    output logic             ref_req,
    output logic             urgent,
    output logic             ready,
    output logic             sr_active,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             addr_oe,
    output logic [ROW_W-1:0] row_addr
);
    localparam int PW = width_for(PAUSE_CYC);
    localparam int BW = width_for(max2(INIT_CNT, ROWS));
    localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [BW-1:0] N_INIT = BW'(INIT_CNT);
    localparam logic [BW-1:0] N_ROWS = BW'(ROWS);

    phase_t           ph;
    logic [PW-1:0]    pcnt;
    logic [BW-1:0]    bcnt;
    logic [BW-1:0]    catch_n;
    logic             start;
    cyc_t             kind;
    cyc_t             norm_kind;
    logic             take;
    logic             owed;
    logic             busy;
    logic             self_low;
    strobe_t          strb;
    logic [ROW_W-1:0] row;
    logic [ROW_W-1:0] row_q;
    logic             step;

    refsched_debt #(.INTERVAL(REF_INTERVAL), .DEBT_MAX(DEBT_MAX)) u_debt (
        .clk(clk), .rst(rst), .run(ph == PH_RUN), .take(take),
        .owed(owed), .urgent(urgent)
    );

    refsched_rowctr #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst(rst), .step(step), .row(row)
    );

    refsched_strobe #(
        .RAS_LOW_CYC(RAS_LOW_CYC), .RP_CYC(RP_CYC),
        .SR_MIN_CYC(SR_MIN_CYC), .SR_EXIT_CYC(SR_EXIT_CYC)
    ) u_strobe (
        .clk(clk), .rst(rst), .start(start), .kind(kind), .hold(sr_req),
        .strb(strb), .busy(busy), .self_low(self_low)
    );

    always_comb begin
        norm_kind = row_mode ? CY_ROR : CY_CBR;
        catch_n   = row_mode ? N_ROWS : BW'(1);
        start     = 1'b0;
        kind      = norm_kind;
        take      = 1'b0;
        case (ph)
            PH_WARM: begin
                start = !busy && (bcnt < N_INIT);
            end
            PH_RUN: begin
                if (ref_grant && !busy) begin
                    if (owed) begin
                        start = 1'b1;
                        take  = 1'b1;
                    end else if (sr_req && !row_mode) begin
                        start = 1'b1;
                        kind  = CY_SELF;
                    end
                end
            end
            PH_SWEEP: begin
                if (!busy) begin
                    start = 1'b1;
                    kind  = (bcnt < N_ROWS) ? CY_ROR : CY_SELF;
                end
            end
            PH_CATCH: begin
                start = !busy && (bcnt < catch_n);
            end
            default: start = 1'b0;
        endcase
        step = start && (kind == CY_ROR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_PAUSE;
            pcnt  <= '0;
            bcnt  <= '0;
            row_q <= '0;
        end else begin
            if (step) row_q <= row;
            case (ph)
                PH_PAUSE: begin
                    if (pcnt == P_LAST) begin
                        ph   <= PH_WARM;
                        bcnt <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_WARM: begin
                    if (start)                          bcnt <= bcnt + 1'b1;
                    else if (!busy && (bcnt == N_INIT)) ph   <= PH_RUN;
                end
                PH_RUN: begin
                    if (ref_grant && !busy && !owed && sr_req) begin
                        if (row_mode) begin
                            ph   <= PH_SWEEP;
                            bcnt <= '0;
                        end else begin
                            ph <= PH_SELF;
                        end
                    end
                end
                PH_SWEEP: begin
                    if (start) begin
                        if (bcnt == N_ROWS) ph   <= PH_SELF;
                        else                bcnt <= bcnt + 1'b1;
                    end
                end
                PH_SELF: begin
                    if (!busy) begin
                        ph   <= PH_CATCH;
                        bcnt <= '0;
                    end
                end
                PH_CATCH: begin
                    if (start)                           bcnt <= bcnt + 1'b1;
                    else if (!busy && (bcnt == catch_n)) ph   <= PH_RUN;
                end
                default: ph <= PH_PAUSE;
            endcase
        end
    end

    always_comb begin
        ready     = (ph != PH_PAUSE) && (ph != PH_WARM);
        ref_req   = ((ph == PH_RUN) && (owed || sr_req || busy)) ||
                    (ph == PH_SWEEP) || (ph == PH_SELF) || (ph == PH_CATCH);
        sr_active = self_low;
        ras_n     = strb.ras_n;
        cas_n     = strb.cas_n;
        addr_oe   = strb.addr_oe;
        we_n      = 1'b1;
        row_addr  = row_q;
    end

endmodule

// File: rtl/refsched_chk.sv
module refsched_chk (
    input logic clk,
    input logic rst,
    input logic row_mode,
    input logic ref_req,
    input logic urgent,
    input logic ready,
    input logic sr_active,
    input logic ras_n,
    input logic cas_n,
    input logic addr_oe
);
    assert_quiet_before_ready_R1: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!ref_req && !urgent))
        else $error("R1: request raised before initialization finished");

    assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0))
        else $error("R3: column strobe did not lead the row strobe");

    assert_precharge_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> ras_n)
        else $error("R4: row strobe precharge too short");

    assert_row_only_addr_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && cas_n) |-> (addr_oe && row_mode))
        else $error("R5: row-only cycle without row address");

    assert_grant_before_use_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && ready) |-> ref_req)
        else $error("R7: refresh started without an active request");

    assert_urgent_has_req_R8: assert property (@(posedge clk) disable iff (rst)
        urgent |-> ref_req)
        else $error("R8: urgent without request");

    assert_self_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        sr_active |-> (!ras_n && !cas_n))
        else $error("R9: self-refresh strobes not both low");

    assert_exit_high_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_active) |=> ras_n)
        else $error("R10: row strobe fell right after self-refresh exit");

endmodule

bind refresh_scheduler refsched_chk i_chk (
    .clk(clk), .rst(rst), .row_mode(row_mode), .ref_req(ref_req),
    .urgent(urgent), .ready(ready), .sr_active(sr_active),
    .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe)
);

// File: tb/test_refresh_scheduler.sv
module test_refresh_scheduler;
    import refsched_pkg::*;

    localparam int P_PAUSE   = 200;
    localparam int P_INIT    = 8;
    localparam int P_INT     = 100;
    localparam int P_DMAX    = 3;
    localparam int P_RL      = 3;
    localparam int P_RP      = 2;
    localparam int P_SR_MIN  = 40;
    localparam int P_SR_EXIT = 5;
    localparam int P_ROWS    = 6;
    localparam int RW        = row_bits(P_ROWS);

    typedef struct packed {
        int expiries;
        int cycles;
        int urg;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1, 1, 0},
        '{2, 2, 0},
        '{3, 3, 1},
        '{4, 3, 1},
        '{5, 3, 1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          row_mode = 1'b0;
    logic          sr_req = 1'b0;
    logic          gnt_man = 1'b0;
    logic          gnt_auto = 1'b0;
    logic          auto_gnt = 1'b0;
    logic          ref_grant;
    logic          ref_req, urgent, ready, sr_active;
    logic          ras_n, cas_n, we_n, addr_oe;
    logic [RW-1:0] row_addr;

    int nchk = 0, nfail = 0;
    int nfall = 0, ncbr = 0, nror = 0;
    int row_err = 0, setup_err = 0, we_err = 0, gap_err = 0;
    int lowc = 0, highc = 0, last_low = 0, last_gap = 0, exp_row = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    assign ref_grant = auto_gnt ? gnt_auto : gnt_man;

    always #10 clk = ~clk;

    refresh_scheduler #(
        .PAUSE_CYC(P_PAUSE), .INIT_CNT(P_INIT), .REF_INTERVAL(P_INT),
        .DEBT_MAX(P_DMAX), .RAS_LOW_CYC(P_RL), .RP_CYC(P_RP),
        .SR_MIN_CYC(P_SR_MIN), .SR_EXIT_CYC(P_SR_EXIT), .ROWS(P_ROWS)
    ) i_refresh_scheduler (
        .clk(clk), .rst(rst), .row_mode(row_mode), .sr_req(sr_req),
        .ref_grant(ref_grant), .ref_req(ref_req), .urgent(urgent),
        .ready(ready), .sr_active(sr_active), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr_oe(addr_oe), .row_addr(row_addr)
    );

    // Strobe monitor, sampled at the falling edge
    always @(negedge clk) begin
        gnt_auto = ref_req;
        if (rst) begin
            exp_row  = 0;
            prev_ras = 1'b1;
            prev_cas = 1'b1;
            lowc     = 0;
            highc    = 0;
        end else begin
            if (prev_ras && !ras_n) begin
                nfall++;
                last_gap = highc;
                if (highc < P_RP) gap_err++;
                highc = 0;
                if (!cas_n) begin
                    ncbr++;
                    if (prev_cas) setup_err++;
                end else if (addr_oe) begin
                    nror++;
                    if (int'(row_addr) != exp_row) row_err++;
                    exp_row = (exp_row + 1) % P_ROWS;
                end
            end
            if (!prev_ras && ras_n) begin
                last_low = lowc;
                lowc     = 0;
            end
            if (!ras_n) begin
                lowc++;
                if (we_n !== 1'b1) we_err++;
            end else begin
                highc++;
            end
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int lim);
        nchk++;
        if (act < lim) begin
            nfail++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    task automatic wait_ready(input int limit);
        for (int i = 0; i < limit && !ready; i++) tick(1);
    endtask

    task automatic wait_req(input logic lvl, input int limit);
        for (int i = 0; i < limit && (ref_req !== lvl); i++) tick(1);
    endtask

    task automatic wait_sr(input logic lvl, input int limit);
        for (int i = 0; i < limit && (sr_active !== lvl); i++) tick(1);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int base, base_c, base_r;

        tick(5);
        // R1 reset state
        chk_eq("R1 ready in reset", int'(ready), 0);
        chk_eq("R1 strobes high in reset", int'({ras_n, cas_n}), 3);
        chk_eq("R1 no request in reset", int'(ref_req), 0);
        rst = 1'b0;
        base = nfall;
        tick(P_PAUSE);
        chk_eq("R1 no RAS fall during pause", nfall - base, 0);

        // R2 warm-up burst, internal-counter style
        wait_ready(P_INIT * 20);
        chk_eq("R2 ready after warm-up", int'(ready), 1);
        chk_eq("R2 warm-up cycle count", nfall - base, P_INIT);
        chk_eq("R2 warm-up cycles are CAS-first", ncbr, P_INIT);
        chk_eq("R4 RAS low width", last_low, P_RL);

        // R6 interval timer
        tick(P_INT - 3);
        chk_eq("R6 no request before interval", int'(ref_req), 0);
        tick(6);
        chk_eq("R6 request after interval", int'(ref_req), 1);

        // R7 / R8 table of grant delays
        foreach (VECS[i]) begin
            wait_req(1'b1, 2 * P_INT);
            base = nfall;
            tick((VECS[i].expiries - 1) * P_INT + P_INT / 2 - 3);
            chk_eq("R7 no refresh without grant", nfall - base, 0);
            chk_eq("R8 urgent at ceiling", int'(urgent), VECS[i].urg);
            gnt_man = 1'b1;
            wait_req(1'b0, 60);
            gnt_man = 1'b0;
            tick(1);
            chk_eq("R7 owed refreshes issued", nfall - base, VECS[i].cycles);
            chk_eq("R8 urgent cleared", int'(urgent), 0);
        end

        // R9 / R10 self-refresh, short request
        auto_gnt = 1'b1;
        base   = nfall;
        base_c = ncbr;
        sr_req = 1'b1;
        wait_sr(1'b1, 20);
        chk_eq("R9 self-refresh active", int'(sr_active), 1);
        chk_eq("R9 both strobes low", int'({ras_n, cas_n}), 0);
        tick(3);
        sr_req = 1'b0;
        wait_sr(1'b0, P_SR_MIN + 20);
        tick(1);
        chk_ge("R9 minimum self-refresh time", last_low, P_SR_MIN);
        wait_req(1'b0, 60);
        tick(1);
        chk_eq("R10 single catch-up after exit", nfall - base, 2);
        chk_eq("R10 catch-up is CAS-first", ncbr - base_c, 2);
        chk_ge("R10 exit recovery", last_gap, P_SR_EXIT);

        // R9 long request
        sr_req = 1'b1;
        wait_sr(1'b1, 20);
        tick(P_SR_MIN + 20);
        chk_eq("R9 held while requested", int'(sr_active & ~ras_n), 1);
        sr_req = 1'b0;
        wait_sr(1'b0, 20);
        tick(1);
        chk_ge("R9 low time follows request", last_low, P_SR_MIN + 20);
        wait_req(1'b0, 60);

        // Row-only style
        rst      = 1'b1;
        row_mode = 1'b1;
        tick(3);
        base   = nfall;
        base_r = nror;
        rst    = 1'b0;
        wait_ready(P_PAUSE + P_INIT * 20);
        chk_eq("R2 row-only warm-up count", nror - base_r, P_INIT);
        chk_eq("R2 row-only warm-up all falls", nfall - base, P_INIT);
        chk_eq("R5 row sequence with wrap", row_err, 0);
        wait_req(1'b1, 2 * P_INT);
        wait_req(1'b0, 40);
        tick(1);
        chk_eq("R5 timed row-only refresh", nror - base_r, P_INIT + 1);

        base   = nfall;
        base_c = ncbr;
        sr_req = 1'b1;
        wait_sr(1'b1, P_ROWS * 10 + 20);
        tick(3);
        sr_req = 1'b0;
        wait_sr(1'b0, P_SR_MIN + 20);
        wait_req(1'b0, P_ROWS * 10 + 20);
        tick(1);
        chk_eq("R11 sweeps around self-refresh", nfall - base, 2 * P_ROWS + 1);
        chk_eq("R11 only self-refresh is CAS-first", ncbr - base_c, 1);
        chk_eq("R5 row sequence after sweeps", row_err, 0);

        chk_eq("R3 CAS setup before RAS", setup_err, 0);
        chk_eq("R3 WE high while RAS low", we_err, 0);
        chk_eq("R4 precharge between cycles", gap_err, 0);
        summary();
    end

endmodule